// File: doc/BRIEF.md
# Weighted Vector Histogram Accumulator

This block folds one vector of 16-bit samples into a bank of 32 accumulator registers. In each sample the low byte names a bucket and the high byte is an unsigned weight. The weight is added to one counter in the bank. Which register and which counter is used depends on both the bucket bits and the sample's position in the vector, so each group of eight neighbouring samples lands in its own slice of every register.

Two counter geometries are offered. In the narrow geometry each register is split into 16-bit counters, and the sums can either wrap or clamp at the top. In the wide geometry adjacent counter pairs act as one 32-bit counter. In that geometry an optional filter keeps only the samples whose bucket bit 0 matches a supplied value. In both geometries a predicate vector can gate individual samples.

A start pulse captures the vector, the predicate and the configuration. The block then walks the samples at one per clock, and a done pulse follows the last update. The bank can be read back at any time as 32-bit words.

Top module: `vhist_accum`

## Requirements
- R1: After reset every counter reads zero, and `busy` and `done` are low.
- R2: For sample i, taken from `vec_in[16*i +: 16]`, bits [7:0] are the bucket and bits [15:8] are the weight, added as an unsigned value. The target register is bucket bits [7:3].
- R3: In narrow mode (`mode_wide`=0) the target 16-bit counter index is (i with bits [2:0] cleared) OR bucket[2:0]. Readback word w of a register returns 16-bit counter 2w in bits [15:0] and counter 2w+1 in bits [31:16].
- R4: In narrow mode with `sat_en`=0, a sum wraps modulo 2^16.
- R5: In narrow mode with `sat_en`=1, a sum above 16'hFFFF is held at 16'hFFFF.
- R6: In wide mode (`mode_wide`=1) the target 32-bit counter, which is readback word index, is ((i>>1) with bits [1:0] cleared) OR bucket[2:1]. Bucket bit 0 does not select the counter, and carries propagate through all 32 bits.
- R7: With `pred_en`=1, sample i updates only when `pred_in[2*i]` is 1, and odd predicate bits have no effect. With `pred_en`=0 every sample updates.
- R8: In wide mode with `match_en`=1, a sample updates only when bucket bit 0 equals `match_val`. This filter combines with the predicate, and `match_en` has no effect in narrow mode.
- R9: A start accepted at clock edge E0 makes `busy` high from E0 until edge E_N, one sample per cycle, where N = `N_ELEM`. `done` is high for exactly the one cycle after E_N, and the updates are visible on readback from then on.
- R10: Inputs are sampled only at an accepted start. A start pulse or a changed vector while `busy` is high has no effect on the result or on the timing.
- R11: Counters keep their values between operations, so successive vectors accumulate.
- R12: `sat_en` has no effect in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode_wide | input | 1 | 0 = 16-bit counters, 1 = 32-bit counters |
| sat_en | input | 1 | Clamp narrow sums at 16'hFFFF |
| pred_en | input | 1 | Gate samples with `pred_in` |
| match_en | input | 1 | Enable the bucket bit 0 filter (wide mode) |
| match_val | input | 1 | Required value of bucket bit 0 |
| vec_in | input | 16*N_ELEM | Sample vector |
| pred_in | input | 2*N_ELEM | Predicate vector, bit 2*i gates sample i |
| rd_reg | input | 5 | Readback register select |
| rd_widx | input | log2(N_ELEM)-1 | Readback 32-bit word select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last sample |
| rd_data | output | 32 | Selected readback word |

## Verification
The bench builds the block with `N_ELEM`=16, so there are two groups of eight samples. This shows that the sample position picks a distinct slice of counters in both geometries, in narrow mode counters 0-7 versus 8-15 and in wide mode words 0-3 versus 4-7. With 16 samples of weight 255, 33 back-to-back operations drive a narrow counter past 16 bits and a wide counter past its lower half. Wrap, clamp and carry are therefore all reached in a few hundred cycles. The whole 32-register bank is compared word by word against a model after every scenario.

// File: rtl/vhist_pkg.sv
package vhist_pkg;
  localparam int VH_REGS  = 32;
  localparam int VH_REG_W = 5;
  localparam int VH_SMP_W = 16;

  typedef enum logic {
    GEOM_NARROW = 1'b0,
    GEOM_WIDE   = 1'b1
  } vh_geom_e;

  typedef struct packed {
    vh_geom_e geom;
    logic     sat;
    logic     pred;
    logic     match;
    logic     match_val;
  } vh_cfg_t;
endpackage

// File: rtl/vhist_seq.sv
module vhist_seq #(
  parameter int N_ELEM = 16,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ELEM - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_last;

  always_comb begin
    accept  = start && !busy_q;
    at_last = busy_q && (idx_q == LAST);
    busy_d  = busy_q;
    idx_d   = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (at_last) busy_d = 1'b0;
    end
    done_d = at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  p_busy_ends_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_idx_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !at_last |=> busy && (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/vhist_decode.sv
module vhist_decode
  import vhist_pkg::*;
#(
  parameter int N_ELEM = 16,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic                       busy,
  input  logic [IDX_W-1:0]           idx,
  input  logic [VH_SMP_W*N_ELEM-1:0] vec,
  input  logic [2*N_ELEM-1:0]        pred,
  input  vh_cfg_t                    cfg,
  output logic                       upd_en,
  output logic [VH_REG_W-1:0]        upd_reg,
  output logic [IDX_W-1:0]           upd_hw,
  output logic [7:0]                 upd_wt
);
  localparam logic [IDX_W-1:0] GRP_MASK = ~IDX_W'(7);

  logic [VH_SMP_W-1:0] sample;
  logic [7:0]          bucket;
  logic                pred_ok, match_ok;

  always_comb begin
    sample  = vec[{idx, 4'b0000} +: VH_SMP_W];
    bucket  = sample[7:0];
    upd_wt  = sample[15:8];
    upd_reg = bucket[7:3];
    if (cfg.geom == GEOM_WIDE)
      upd_hw = (idx & GRP_MASK) | IDX_W'({bucket[2:1], 1'b0});
    else
      upd_hw = (idx & GRP_MASK) | IDX_W'(bucket[2:0]);
    pred_ok  = !cfg.pred || pred[{idx, 1'b0}];
    match_ok = !(cfg.geom == GEOM_WIDE && cfg.match) || (bucket[0] == cfg.match_val);
    upd_en   = busy && pred_ok && match_ok;
  end
endmodule

// File: rtl/vhist_alu.sv
module vhist_alu
  import vhist_pkg::*;
(
  input  vh_geom_e    geom,
  input  logic        sat,
  input  logic [31:0] opnd,
  input  logic [7:0]  wt,
  output logic [31:0] res
);
  logic [16:0] sum_n;
  logic [31:0] sum_w;

  always_comb begin
    sum_n = {1'b0, opnd[15:0]} + {9'b0, wt};
    sum_w = opnd + {24'b0, wt};
    if (geom == GEOM_WIDE)
      res = sum_w;
    else if (sat && sum_n[16])
      res = {16'b0, 16'hFFFF};
    else
      res = {16'b0, sum_n[15:0]};
  end
endmodule

// File: rtl/vhist_bank.sv
module vhist_bank
  import vhist_pkg::*;
#(
  parameter int N_ELEM = 16,
  localparam int IDX_W  = $clog2(N_ELEM),
  localparam int WIDX_W = IDX_W - 1,
  localparam int CELLS  = VH_REGS * N_ELEM,
  localparam int ADDR_W = VH_REG_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_wide,
  input  logic [VH_REG_W-1:0] wr_reg,
  input  logic [IDX_W-1:0]    wr_hw,
  input  logic [31:0]         wr_data,
  output logic [31:0]         op_data,
  input  logic [VH_REG_W-1:0] rd_reg,
  input  logic [WIDX_W-1:0]   rd_widx,
  output logic [31:0]         rd_data
);
  logic [CELLS*16-1:0] flat;
  logic [ADDR_W-1:0]   lo_addr, hi_addr, rlo_addr, rhi_addr;

  always_comb begin
    lo_addr  = {wr_reg, wr_hw};
    hi_addr  = {wr_reg, wr_hw | IDX_W'(1)};
    rlo_addr = {rd_reg, rd_widx, 1'b0};
    rhi_addr = {rd_reg, rd_widx, 1'b1};
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic        sel_lo, sel_hi;
    logic [15:0] d, q;
    always_comb begin
      sel_lo = wr_en && (lo_addr == ADDR_W'(c));
      sel_hi = wr_en && wr_wide && (hi_addr == ADDR_W'(c));
      d      = sel_hi ? wr_data[31:16] : wr_data[15:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= '0;
      else if (sel_lo || sel_hi) q <= d;
    end
    assign flat[c*16 +: 16] = q;
  end

  always_comb begin
    if (wr_wide)
      op_data = {flat[{hi_addr, 4'b0000} +: 16], flat[{lo_addr, 4'b0000} +: 16]};
    else
      op_data = {16'b0, flat[{lo_addr, 4'b0000} +: 16]};
    rd_data = {flat[{rhi_addr, 4'b0000} +: 16], flat[{rlo_addr, 4'b0000} +: 16]};
  end

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) && $stable(rd_reg) && $stable(rd_widx) |-> $stable(rd_data));
  p_wide_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_wide |-> !wr_hw[0]);
endmodule

// File: rtl/vhist_accum.sv
module vhist_accum
  import vhist_pkg::*;
#(
  parameter int N_ELEM = 16,
  localparam int IDX_W  = $clog2(N_ELEM),
  localparam int WIDX_W = IDX_W - 1,
  localparam int VEC_W  = VH_SMP_W * N_ELEM
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode_wide,
  input  logic                sat_en,
  input  logic                pred_en,
  input  logic                match_en,
  input  logic                match_val,
  input  logic [VEC_W-1:0]    vec_in,
  input  logic [2*N_ELEM-1:0] pred_in,
  input  logic [VH_REG_W-1:0] rd_reg,
  input  logic [WIDX_W-1:0]   rd_widx,
  output logic                busy,
  output logic                done,
  output logic [31:0]         rd_data
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic             accept;
  logic [IDX_W-1:0] idx;

  vhist_seq #(.N_ELEM(N_ELEM)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .accept(accept),
    .busy(busy), .done(done), .idx(idx)
  );

  logic [VEC_W-1:0]    vec_q, vec_d;
  logic [2*N_ELEM-1:0] pred_q, pred_d;
  vh_cfg_t             cfg_q, cfg_d;

  always_comb begin
    vec_d  = vec_q;
    pred_d = pred_q;
    cfg_d  = cfg_q;
    if (accept) begin
      vec_d           = vec_in;
      pred_d          = pred_in;
      cfg_d.geom      = mode_wide ? GEOM_WIDE : GEOM_NARROW;
      cfg_d.sat       = sat_en;
      cfg_d.pred      = pred_en;
      cfg_d.match     = match_en;
      cfg_d.match_val = match_val;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vec_q  <= '0;
      pred_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      vec_q  <= vec_d;
      pred_q <= pred_d;
      cfg_q  <= cfg_d;
    end
  end

  logic                upd_en;
  logic [VH_REG_W-1:0] upd_reg;
  logic [IDX_W-1:0]    upd_hw;
  logic [7:0]          upd_wt;
  logic [31:0]         opnd, res;

  vhist_decode #(.N_ELEM(N_ELEM)) u_dec (
    .busy(busy), .idx(idx), .vec(vec_q), .pred(pred_q), .cfg(cfg_q),
    .upd_en(upd_en), .upd_reg(upd_reg), .upd_hw(upd_hw), .upd_wt(upd_wt)
  );

  vhist_alu u_alu (
    .geom(cfg_q.geom), .sat(cfg_q.sat), .opnd(opnd), .wt(upd_wt), .res(res)
  );

  vhist_bank #(.N_ELEM(N_ELEM)) u_bank (
    .clk(clk), .rst_n(rst_s),
    .wr_en(upd_en), .wr_wide(cfg_q.geom == GEOM_WIDE),
    .wr_reg(upd_reg), .wr_hw(upd_hw), .wr_data(res), .op_data(opnd),
    .rd_reg(rd_reg), .rd_widx(rd_widx), .rd_data(rd_data)
  );

  logic [15:0] cur_smp;
  logic        narrow_carry;
  assign cur_smp      = vec_q[{idx, 4'b0000} +: 16];
  assign narrow_carry = ({1'b0, opnd[15:0]} + {9'b0, upd_wt}) > 17'h0FFFF;

  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !upd_en);
  p_operands_held_r10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> $stable(vec_q) && $stable(pred_q) && $stable(cfg_q));
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_s)
    upd_en && cfg_q.geom == GEOM_NARROW && cfg_q.sat && narrow_carry |-> res[15:0] == 16'hFFFF);
  p_match_gate_r8: assert property (@(posedge clk) disable iff (!rst_s)
    upd_en && cfg_q.geom == GEOM_WIDE && cfg_q.match |-> cur_smp[0] == cfg_q.match_val);
  p_pred_gate_r7: assert property (@(posedge clk) disable iff (!rst_s)
    upd_en && cfg_q.pred |-> pred_q[{idx, 1'b0}]);
  p_reg_pick_r2: assert property (@(posedge clk) disable iff (!rst_s)
    upd_en |-> upd_reg == cur_smp[7:3]);
endmodule

// File: tb/sim_vhist_accum.sv
`timescale 1ns/1ps
module sim_vhist_accum;
  localparam int N  = 16;
  localparam int VW = 16 * N;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, mode_wide, sat_en, pred_en, match_en, match_val;
  logic [VW-1:0] vec_in;
  logic [2*N-1:0] pred_in;
  logic [4:0]    rd_reg;
  logic [2:0]    rd_widx;
  logic          busy, done;
  logic [31:0]   rd_data;

  always #2 clk = ~clk;

  vhist_accum #(.N_ELEM(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_wide(mode_wide),
    .sat_en(sat_en), .pred_en(pred_en), .match_en(match_en), .match_val(match_val),
    .vec_in(vec_in), .pred_in(pred_in), .rd_reg(rd_reg), .rd_widx(rd_widx),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  int unsigned mdl [32][N];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic rnd_vec(output logic [VW-1:0] v);
    for (int i = 0; i < N; i++) begin
      seed = lcg(seed);
      v[16*i +: 16] = seed[23:8];
    end
  endtask

  task automatic rnd_pred(output logic [2*N-1:0] p);
    seed = lcg(seed);
    p = seed[2*N-1:0];
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 0; mode_wide = 0; sat_en = 0; pred_en = 0;
    match_en = 0; match_val = 0; vec_in = '0; pred_in = '0; rd_reg = '0; rd_widx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < 32; r++)
      for (int h = 0; h < N; h++) mdl[r][h] = 0;
  endtask

  task automatic model(input logic [VW-1:0] v, input logic [2*N-1:0] p,
                       input logic w, input logic s, input logic pe,
                       input logic me, input logic mv);
    for (int i = 0; i < N; i++) begin
      logic [7:0] b;
      int unsigned wt, r, hw, sum;
      b  = v[16*i +: 8];
      wt = v[16*i+8 +: 8];
      r  = b[7:3];
      if (pe && !p[2*i]) continue;
      if (w && me && (b[0] != mv)) continue;
      if (!w) begin
        hw  = (i & ~7) | b[2:0];
        sum = mdl[r][hw] + wt;
        if (s && sum > 65535) sum = 65535;
        mdl[r][hw] = sum & 32'hFFFF;
      end else begin
        hw  = (i & ~7) | (b[2:1] << 1);
        sum = ((mdl[r][hw+1] << 16) | mdl[r][hw]) + wt;
        mdl[r][hw]   = sum & 32'hFFFF;
        mdl[r][hw+1] = sum >> 16;
      end
    end
  endtask

  task automatic run_op(input logic [VW-1:0] v, input logic [2*N-1:0] p,
                        input logic w, input logic s, input logic pe,
                        input logic me, input logic mv, input logic inject,
                        input string tag);
    bit ok = 1;
    int bad_k = 0;
    vec_in = v; pred_in = p; mode_wide = w; sat_en = s; pred_en = pe;
    match_en = me; match_val = mv; start = 1'b1;
    for (int k = 1; k <= N + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        vec_in = ~v;
      end
      if (inject && k == 3) begin
        start = 1'b1; mode_wide = ~w; sat_en = ~s; pred_en = ~pe;
      end
      if (inject && k == 4) start = 1'b0;
      if (k <= N && (busy !== 1'b1 || done !== 1'b0)) begin ok = 0; bad_k = k; end
      if (k == N + 1 && (done !== 1'b1 || busy !== 1'b0)) begin ok = 0; bad_k = k; end
    end
    model(v, p, w, s, pe, me, mv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R9 %s: busy/done wrong in cycle %0d (busy=%b done=%b), expected busy high N cycles then done pulse",
               tag, bad_k, busy, done);
    end
    @(negedge clk);
  endtask

  task automatic check_bank(input string req);
    int errs = 0;
    for (int r = 0; r < 32; r++)
      for (int w = 0; w < N/2; w++) begin
        logic [31:0] exp;
        rd_reg = r[4:0]; rd_widx = w[2:0];
        #1;
        exp = {mdl[r][2*w+1][15:0], mdl[r][2*w][15:0]};
        if (rd_data !== exp) begin
          if (errs < 4)
            $display("FAIL %s: reg %0d word %0d got %h expected %h", req, r, w, rd_data, exp);
          errs++;
        end
      end
    n_chk++;
    if (errs != 0) n_bad++;
  endtask

  task automatic check_word(input int r, input int w, input logic [31:0] exp, input string req);
    rd_reg = r[4:0]; rd_widx = w[2:0];
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: reg %0d word %0d got %h expected %h", req, r, w, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    n_chk++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: busy=%b done=%b expected 0 0", busy, done);
    end
    check_bank("R1");
  endtask

  task automatic t_narrow();
    logic [VW-1:0] v;
    do_reset();
    v = '0;
    for (int i = 0; i < N; i++) v[16*i +: 16] = 16'h0000;
    v[16*9 +: 16] = 16'h802D;  // R2/R3: reg 5, counter (8|5)=13, weight 0x80
    run_op(v, '0, 0, 0, 0, 0, 0, 0, "narrow_directed");
    check_word(5, 6, 32'h0080_0000, "R3");
    check_word(0, 0, 32'h0000_0000, "R2");   // weight 0 left reg 0 counter 0 unchanged
    rnd_vec(v);
    run_op(v, '0, 0, 0, 0, 1, 1, 0, "narrow_rand");  // match_en ignored in narrow (R8)
    check_bank("R3");
    rnd_vec(v);
    run_op(v, '0, 0, 0, 0, 0, 0, 0, "narrow_accum");
    check_bank("R11");
  endtask

  task automatic t_wrap_sat();
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) v[16*i +: 16] = 16'hFF00;
    do_reset();
    for (int k = 0; k < 33; k++) run_op(v, '0, 0, 0, 0, 0, 0, 0, "wrap");
    check_word(0, 0, 32'h0000_06F8, "R4");   // 8*255*33 mod 2^16 = 0x06F8
    check_word(0, 4, 32'h0000_06F8, "R4");
    check_bank("R4");
    do_reset();
    for (int k = 0; k < 33; k++) run_op(v, '0, 0, 1, 0, 0, 0, 0, "sat");
    check_word(0, 0, 32'h0000_FFFF, "R5");
    check_bank("R5");
  endtask

  task automatic t_wide();
    logic [VW-1:0] v;
    do_reset();
    for (int i = 0; i < N; i++) v[16*i +: 16] = 16'hFF01;  // bucket bit0 set, word 0/4
    for (int k = 0; k < 33; k++) run_op(v, '0, 1, 1, 0, 0, 0, 0, "wide_carry");
    check_word(0, 0, 32'h0001_06F8, "R6");   // carry past 16 bits, sat ignored (R12)
    check_word(0, 4, 32'h0001_06F8, "R12");
    rnd_vec(v);
    run_op(v, '0, 1, 0, 0, 0, 0, 0, "wide_rand");
    check_bank("R6");
  endtask

  task automatic t_pred();
    logic [VW-1:0] v;
    logic [2*N-1:0] p;
    do_reset();
    rnd_vec(v);
    run_op(v, {N{2'b10}}, 0, 0, 1, 0, 0, 0, "pred_odd_only");
    check_bank("R7");  // only odd bits set: bank stays zero
    rnd_vec(v); rnd_pred(p);
    run_op(v, p, 0, 0, 1, 0, 0, 0, "pred_narrow");
    rnd_vec(v); rnd_pred(p);
    run_op(v, p, 1, 0, 1, 0, 0, 0, "pred_wide");
    check_bank("R7");
  endtask

  task automatic t_match();
    logic [VW-1:0] v;
    logic [2*N-1:0] p;
    do_reset();
    rnd_vec(v);
    run_op(v, '0, 1, 0, 0, 1, 0, 0, "match0");
    rnd_vec(v);
    run_op(v, '0, 1, 0, 0, 1, 1, 0, "match1");
    check_bank("R8");
    rnd_vec(v); rnd_pred(p);
    run_op(v, p, 1, 0, 1, 1, 1, 0, "match_pred");
    check_bank("R8");
  endtask

  task automatic t_busy_start();
    logic [VW-1:0] v;
    do_reset();
    rnd_vec(v);
    run_op(v, '0, 0, 0, 0, 0, 0, 1, "restart_ignored");
    check_bank("R10");
  endtask

  bit finished = 0;

  initial begin
    t_reset();
    t_narrow();
    t_wrap_sat();
    t_wide();
    t_pred();
    t_match();
    t_busy_start();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: run exceeded %0d cycles, expected completion", 100000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule